// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Single-Bit Operation Unit

This unit carries out the bit-manipulation instruction group of an 8-bit processor on one operand byte. It covers four rotates (circular and through-carry, each in both directions), three shifts (arithmetic left, arithmetic right, logical right), a nibble swap, and three single-bit operations: test, clear and set. Memory access and instruction decode sit outside it. The decoder supplies the operand, an operation code, a bit index and the current flag nibble. It takes back the result byte, the new flag nibble and a write-enable that says whether the result should be stored.

The unit is purely combinational. It has no register, no state and no clock. The processor's execute stage samples the outputs in the same cycle it presents the inputs. A separate input marks the four short one-byte accumulator rotate encodings. Their flag rule differs from the two-byte prefixed rotates only in the zero flag.

Top module: `srb_unit`

## Requirements
- R1: Op code 0 rotates left circularly and op code 1 rotates right circularly. The bit that leaves the byte enters the opposite end and is also copied to C (flag bit 0).
- R2: Op code 2 rotates left and op code 3 rotates right, both through carry. The incoming C enters the vacated end and the bit that leaves goes to C.
- R3: Op code 4 shifts left arithmetically. Bit 7 goes to C and bit 0 becomes 0.
- R4: Op code 5 shifts right arithmetically and keeps bit 7 unchanged. Op code 7 shifts right logically and puts 0 in bit 7. Both move bit 0 into C.
- R5: Op codes 0 to 7 clear N (flag bit 2) and H (flag bit 1). Z (flag bit 3) is set when the result is zero, except when the short-form input is high on a rotate (op codes 0 to 3), in which case Z is forced to 0.
- R6: The short-form input has no effect on op codes 4 and above.
- R7: Op code 6 exchanges the upper and lower nibbles and clears C.
- R8: Op code 8 tests the indexed bit, where index 0 is the least significant bit. It sets Z when that bit is 0, clears N, sets H, keeps C from the flag input, returns the operand unchanged and holds write-enable low.
- R9: Op code 9 clears the indexed bit and op code 10 sets it. No other bit changes, and all four flags pass through from the flag input.
- R10: Write-enable is high for op codes 0 to 7, 9 and 10. Op codes 11 to 15 return the operand with the flags unchanged and write-enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 8 | Byte to operate on |
| bit_sel_i | input | 3 | Bit index for test, clear and set |
| op_i | input | 4 | Operation code |
| short_form_i | input | 1 | Marks the one-byte accumulator rotate encodings |
| flags_i | input | 4 | Current flags {Z,N,H,C}; C is the incoming carry |
| result_o | output | 8 | Result byte |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| wr_en_o | output | 1 | Result must be written back |

## Verification
Every result, flag and write-enable is due in the same cycle its inputs are applied, because no register lies on any path. The bench changes inputs on the falling edge of its 125 MHz clock and samples one nanosecond after the next rising edge, when the outputs have settled. The sweep covers every op code, every operand value, both carry values and both short-form values. For the three single-bit operations it also covers every bit index. The expected values come from arithmetic (multiplication, division and modulo) rather than from bit slicing.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [3:0] {
        OP_RLC  = 4'd0,
        OP_RRC  = 4'd1,
        OP_RL   = 4'd2,
        OP_RR   = 4'd3,
        OP_SLA  = 4'd4,
        OP_SRA  = 4'd5,
        OP_SWAP = 4'd6,
        OP_SRL  = 4'd7,
        OP_BTST = 4'd8,
        OP_BCLR = 4'd9,
        OP_BSET = 4'd10
    } srb_op_e;

    localparam int FLAG_Z = 3;
    localparam int FLAG_N = 2;
    localparam int FLAG_H = 1;
    localparam int FLAG_C = 0;
    localparam int FLAG_W = 4;

endpackage

// File: rtl/srb_shifter.sv
module srb_shifter
    import srb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [3:0]       op_i,
    input  logic             cin_i,
    input  logic             short_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             zero_o,
    output logic             hit_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] swapped;
    logic             is_rot;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_swap
            assign swapped[gi] = val_i[(gi + HALF) % WIDTH];
        end
    endgenerate

    always_comb begin
        res_o  = val_i;
        cout_o = 1'b0;
        hit_o  = 1'b1;
        unique case (srb_op_e'(op_i))
            OP_RLC:  begin res_o = {val_i[WIDTH-2:0], val_i[WIDTH-1]}; cout_o = val_i[WIDTH-1]; end
            OP_RRC:  begin res_o = {val_i[0], val_i[WIDTH-1:1]};       cout_o = val_i[0];       end
            OP_RL:   begin res_o = {val_i[WIDTH-2:0], cin_i};          cout_o = val_i[WIDTH-1]; end
            OP_RR:   begin res_o = {cin_i, val_i[WIDTH-1:1]};          cout_o = val_i[0];       end
            OP_SLA:  begin res_o = {val_i[WIDTH-2:0], 1'b0};           cout_o = val_i[WIDTH-1]; end
            OP_SRA:  begin res_o = {val_i[WIDTH-1], val_i[WIDTH-1:1]}; cout_o = val_i[0];       end
            OP_SWAP: begin res_o = swapped;                            cout_o = 1'b0;           end
            OP_SRL:  begin res_o = {1'b0, val_i[WIDTH-1:1]};           cout_o = val_i[0];       end
            default: hit_o = 1'b0;
        endcase
    end

    assign is_rot = (op_i[3:2] == 2'b00);

    always_comb begin
        zero_o = (res_o == '0);
        if (is_rot && short_i) begin
            zero_o = 1'b0;
        end
    end

    always_comb begin
        if (!$isunknown({val_i, op_i, cin_i, short_i})) begin
            // R1
            rlc_wrap_chk: assert (!(op_i == 4'd0) || (res_o[0] == cout_o))
                else $error("circular left rotate lost the wrapped bit");
            // R2
            rl_carry_in_chk: assert (!(op_i == 4'd2) || (res_o[0] == cin_i))
                else $error("through-carry rotate did not take the old carry");
            // R3
            sla_fill_chk: assert (!(op_i == 4'd4) || (!res_o[0] && cout_o == val_i[WIDTH-1]))
                else $error("left shift fill or carry wrong");
            // R4
            sra_sign_chk: assert (!(op_i == 4'd5) || (res_o[WIDTH-1] == val_i[WIDTH-1]))
                else $error("arithmetic right shift changed bit 7");
            // R4
            srl_fill_chk: assert (!(op_i == 4'd7) || !res_o[WIDTH-1])
                else $error("logical right shift did not fill with 0");
            // R5
            short_z_chk: assert (!(is_rot && short_i) || !zero_o)
                else $error("short rotate form reported zero");
        end
    end

endmodule

// File: rtl/srb_bitops.sv
module srb_bitops
    import srb_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             bit_zero_o,
    output logic             is_test_o,
    output logic             hit_o
);
    logic [WIDTH-1:0] mask;

    assign mask       = {{(WIDTH-1){1'b0}}, 1'b1} << idx_i;
    assign bit_zero_o = !val_i[idx_i];

    always_comb begin
        res_o     = val_i;
        is_test_o = 1'b0;
        hit_o     = 1'b1;
        unique case (srb_op_e'(op_i))
            OP_BTST: is_test_o = 1'b1;
            OP_BCLR: res_o = val_i & ~mask;
            OP_BSET: res_o = val_i | mask;
            default: hit_o = 1'b0;
        endcase
    end

    always_comb begin
        if (!$isunknown({val_i, idx_i, op_i})) begin
            // R9
            only_index_chk: assert (((res_o ^ val_i) >> idx_i) <= 1)
                else $error("bit operation touched a higher bit");
            // R9
            low_bits_chk: assert (((res_o ^ val_i) & ((mask << 1) - 1)) == (res_o ^ val_i))
                else $error("bit operation touched a higher bit");
            // R8
            test_keep_chk: assert (!is_test_o || (res_o == val_i))
                else $error("bit test changed the operand");
        end
    end

endmodule

// File: rtl/srb_unit.sv
module srb_unit
    import srb_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]  operand_i,
    input  logic [IDX_W-1:0]  bit_sel_i,
    input  logic [3:0]        op_i,
    input  logic              short_form_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [WIDTH-1:0]  result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_en_o
);
    logic [WIDTH-1:0] sh_res;
    logic             sh_cout;
    logic             sh_zero;
    logic             sh_hit;
    logic [WIDTH-1:0] bo_res;
    logic             bo_zero;
    logic             bo_test;
    logic             bo_hit;

    srb_shifter #(.WIDTH(WIDTH)) u_shifter (
        .val_i   (operand_i),
        .op_i    (op_i),
        .cin_i   (flags_i[FLAG_C]),
        .short_i (short_form_i),
        .res_o   (sh_res),
        .cout_o  (sh_cout),
        .zero_o  (sh_zero),
        .hit_o   (sh_hit)
    );

    srb_bitops #(.WIDTH(WIDTH)) u_bitops (
        .val_i      (operand_i),
        .idx_i      (bit_sel_i),
        .op_i       (op_i),
        .res_o      (bo_res),
        .bit_zero_o (bo_zero),
        .is_test_o  (bo_test),
        .hit_o      (bo_hit)
    );

    always_comb begin
        result_o = operand_i;
        flags_o  = flags_i;
        wr_en_o  = 1'b0;
        if (sh_hit) begin
            result_o         = sh_res;
            flags_o          = '0;
            flags_o[FLAG_Z]  = sh_zero;
            flags_o[FLAG_C]  = sh_cout;
            wr_en_o          = 1'b1;
        end else if (bo_hit) begin
            result_o = bo_res;
            if (bo_test) begin
                flags_o[FLAG_Z] = bo_zero;
                flags_o[FLAG_N] = 1'b0;
                flags_o[FLAG_H] = 1'b1;
            end else begin
                wr_en_o = 1'b1;
            end
        end
    end

    always_comb begin
        if (!$isunknown({operand_i, bit_sel_i, op_i, short_form_i, flags_i})) begin
            // R10
            test_no_write_chk: assert (!(op_i == 4'd8) || !wr_en_o)
                else $error("bit test requested a write");
            // R5
            shift_nh_chk: assert (!(op_i < 4'd8) || (!flags_o[FLAG_N] && !flags_o[FLAG_H]))
                else $error("shift group left N or H set");
            // R7
            swap_carry_chk: assert (!(op_i == 4'd6) || !flags_o[FLAG_C])
                else $error("swap left carry set");
            // R9
            bit_flags_keep_chk: assert (!(op_i == 4'd9 || op_i == 4'd10) || (flags_o == flags_i))
                else $error("bit clear or set altered flags");
            // R8
            test_carry_chk: assert (!(op_i == 4'd8) || (flags_o[FLAG_C] == flags_i[FLAG_C] && flags_o[FLAG_H]))
                else $error("bit test flag rule broken");
            // R10
            undef_op_chk: assert (!(op_i > 4'd10) || (!wr_en_o && result_o == operand_i && flags_o == flags_i))
                else $error("undefined op code had an effect");
        end
    end

endmodule

// File: tb/test_srb_unit.sv
module test_srb_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] operand;
    logic [2:0] bit_sel;
    logic [3:0] op;
    logic       short_form;
    logic [3:0] flags_in;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic       wr_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    srb_unit i_srb_unit (
        .operand_i    (operand),
        .bit_sel_i    (bit_sel),
        .op_i         (op),
        .short_form_i (short_form),
        .flags_i      (flags_in),
        .result_o     (result),
        .flags_o      (flags_out),
        .wr_en_o      (wr_en)
    );

    function automatic string req_of(int o, bit s);
        if (s && o < 4) return "R5";
        if (s && o >= 4) return "R6";
        case (o)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4:       return "R3";
            5, 7:    return "R4";
            6:       return "R7";
            8:       return "R8";
            9, 10:   return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic model(input int o, input int v, input int idx, input int c, input bit s,
                         input logic [3:0] fin, output logic [7:0] r, output logic [3:0] f,
                         output logic w);
        int rv;
        int cc;
        int pw;
        pw = 1;
        for (int k = 0; k < idx; k++) pw = pw * 2;
        rv = v;
        cc = 0;
        w  = 1'b1;
        f  = fin;
        case (o)
            0: begin rv = (v * 2) % 256 + v / 128;       cc = v / 128; end
            1: begin rv = v / 2 + (v % 2) * 128;         cc = v % 2;   end
            2: begin rv = (v * 2) % 256 + c;             cc = v / 128; end
            3: begin rv = v / 2 + c * 128;               cc = v % 2;   end
            4: begin rv = (v * 2) % 256;                 cc = v / 128; end
            5: begin rv = v / 2 + (v / 128) * 128;       cc = v % 2;   end
            6: begin rv = (v % 16) * 16 + v / 16;        cc = 0;       end
            7: begin rv = v / 2;                         cc = v % 2;   end
            8: begin
                rv = v;
                w  = 1'b0;
                f  = {((v / pw) % 2 == 0), 1'b0, 1'b1, fin[0]};
            end
            9:  rv = ((v / pw) % 2 == 1) ? v - pw : v;
            10: rv = ((v / pw) % 2 == 0) ? v + pw : v;
            default: w = 1'b0;
        endcase
        if (o < 8) begin
            f = {((s && o < 4) ? 1'b0 : (rv == 0)), 1'b0, 1'b0, (cc != 0)};
        end
        r = 8'(rv);
    endtask

    task automatic check(input string req, input logic [7:0] er, input logic [3:0] ef, input logic ew);
        checks++;
        if (result !== er || flags_out !== ef || wr_en !== ew) begin
            fails++;
            $display("FAIL %s op=%0d in=%02h idx=%0d short=%0b flags_in=%04b: actual res=%02h flags=%04b wr=%0b expected res=%02h flags=%04b wr=%0b",
                     req, op, operand, bit_sel, short_form, flags_in,
                     result, flags_out, wr_en, er, ef, ew);
        end
    endtask

    task automatic apply(input int o, input int v, input int idx, input int c, input bit s);
        logic [7:0] er;
        logic [3:0] ef;
        logic       ew;
        logic [3:0] fin;
        fin = {v[7] ^ s, v[6], v[5], c[0]};
        @(negedge clk);
        op         = 4'(o);
        operand    = 8'(v);
        bit_sel    = 3'(idx);
        short_form = s;
        flags_in   = fin;
        model(o, v, idx, c, s, fin, er, ef, ew);
        @(posedge clk);
        #1;
        check(req_of(o, s), er, ef, ew);
    endtask

    initial begin
        operand    = 8'h00;
        bit_sel    = 3'd0;
        op         = 4'd0;
        short_form = 1'b0;
        flags_in   = 4'b0000;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R5: idle inputs (rotate of zero) must report Z set and a write
        check("R5", 8'h00, 4'b1000, 1'b1);
        for (int o = 0; o < 16; o++) begin
            for (int v = 0; v < 256; v++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int s = 0; s < 2; s++) begin
                        if (o >= 8 && o <= 10) begin
                            for (int idx = 0; idx < 8; idx++) apply(o, v, idx, c, s[0]);
                        end else begin
                            apply(o, v, v % 8, c, s[0]);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=sweep complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule